// File: doc/BRIEF.md
# Pipelined Murmur Hash Partition Selector

This block assigns each incoming 64-bit tuple to a partition. A tuple is a 32-bit key with a 32-bit payload. One tuple can enter on every clock. After a fixed five-cycle pipeline, the tuple comes out unchanged together with an `IDX_W`-bit partition index. A wide input line of eight tuples is served by eight side-by-side copies of this block.

The partition index is computed in one of two modes.

- **Hash mode** runs a 32-bit murmur-style finalizer over the key. The finalizer has five steps and each step sits in its own register stage. The index is the low bits of the mixed word.
- **Radix mode** carries the raw key through the same five stages without changing it. The index is then the low bits of the key itself.

Because both modes have the same latency, a stream never reorders results when the mode changes. The mode input is sampled only while no tuple is in flight. A tuple that enters an empty pipeline uses the mode present on that same cycle. When the downstream consumer lowers its ready signal, the whole pipeline freezes in place.

Top module: `tuple_part_sel`

## Requirements
- R1: In hash mode, the index equals the low `IDX_W` bits of the mixed key. The mix is computed on 32-bit words, and each product keeps only its low 32 bits. The five steps are:
  - x ^= x >> 16
  - x *= 0x85ebca6b
  - x ^= x >> 13
  - x *= 0xc2b2ae35
  - x ^= x >> 16
- R2: In radix mode (`hash_mode_i` = 0), the index equals the low `IDX_W` bits of the unmodified key.
- R3: The key and payload leave the block bit-for-bit unchanged, paired with their own index.
- R4: A tuple accepted on a clock edge appears on the outputs with `out_valid_o` high after exactly five accepting edges. No output appears without a matching input.
- R5: Back-to-back tuples are accepted and delivered one per cycle, in order, with no internal bubble.
- R6: While `out_ready_i` is low, no stage advances. The output valid, key, payload and index hold their values. `in_ready_o` equals `out_ready_i`.
- R7: A change on `hash_mode_i` while any tuple is in flight has no effect on tuples accepted until the pipeline drains. Once the pipeline is empty, the new mode applies from the very next accepted tuple.
- R8: While reset is asserted, and on the first cycle after it, `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input tuple valid |
| in_key_i | input | 32 | Tuple key |
| in_payload_i | input | 32 | Tuple payload |
| hash_mode_i | input | 1 | 1 = hash mode, 0 = radix mode |
| out_ready_i | input | 1 | Downstream can take a result; low freezes the pipeline |
| in_ready_o | output | 1 | Block can take a tuple this cycle |
| out_valid_o | output | 1 | Output tuple valid |
| out_key_o | output | 32 | Key of the output tuple |
| out_payload_o | output | 32 | Payload of the output tuple |
| out_index_o | output | IDX_W | Partition index of the output tuple |

## Verification
Several properties are checked on every cycle:

- Every valid output index matches a single-step reference of the finalizer, or the raw key bits in radix mode.
- A stalled output holds its value.
- Every stage is frozen while downstream is not ready.
- All tuples in flight share one mode.

Other behaviours only the directed scenarios can show:

- The exact five-cycle latency.
- Ordering and pairing of payload with key across bursts.
- One-per-cycle throughput.
- Survival of data across a stall.
- That a mode change made during a burst takes effect only after the drain.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned KEY_W  = 32;
  localparam int unsigned PAY_W  = 32;
  localparam int unsigned STAGES = 5;
  localparam logic [KEY_W-1:0] MIX_MUL_A = 32'h85ebca6b;
  localparam logic [KEY_W-1:0] MIX_MUL_B = 32'hc2b2ae35;

  // one finalizer step; products keep the low word only
  function automatic logic [KEY_W-1:0] mix_step(input int unsigned step,
                                                input logic [KEY_W-1:0] w);
    logic [KEY_W-1:0] r;
    case (step)
      0:       r = w ^ (w >> 16);
      1:       r = w * MIX_MUL_A;
      2:       r = w ^ (w >> 13);
      3:       r = w * MIX_MUL_B;
      default: r = w ^ (w >> 16);
    endcase
    return r;
  endfunction

  function automatic logic [KEY_W-1:0] mix_full(input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] w;
    w = k;
    for (int unsigned s = 0; s < STAGES; s++) w = mix_step(s, w);
    return w;
  endfunction
endpackage

// File: rtl/tps_mode_ctl.sv
module tps_mode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic mode_i,
  output logic mode_o
);
  logic mode_q;
  logic mode_d;

  // the mode is only taken from the pin while nothing is in flight
  always_comb begin
    mode_d = busy_i ? mode_q : mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_d;
endmodule

// File: rtl/tps_mix_stage.sv
module tps_mix_stage
  import tps_pkg::*;
#(
  parameter int unsigned STEP = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic             hash_i,
  input  logic [KEY_W-1:0] word_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic             vld_o,
  output logic             hash_o,
  output logic [KEY_W-1:0] word_o,
  output logic [KEY_W-1:0] key_o,
  output logic [PAY_W-1:0] pay_o
);
  logic [KEY_W-1:0] word_d;

  // radix tuples pass the word through untouched, with the same latency
  always_comb begin
    word_d = hash_i ? mix_step(STEP, word_i) : word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      hash_o <= 1'b0;
      word_o <= '0;
      key_o  <= '0;
      pay_o  <= '0;
    end else if (en_i) begin
      vld_o  <= vld_i;
      hash_o <= hash_i;
      word_o <= word_d;
      key_o  <= key_i;
      pay_o  <= pay_i;
    end
  end

  // R6
  stage_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(vld_o) && $stable(word_o) && $stable(key_o) && $stable(pay_o));
endmodule

// File: rtl/tuple_part_sel.sv
module tuple_part_sel
  import tps_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [31:0]      in_key_i,
  input  logic [31:0]      in_payload_i,
  input  logic             hash_mode_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [31:0]      out_key_o,
  output logic [31:0]      out_payload_o,
  output logic [IDX_W-1:0] out_index_o
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0]            vld;
  logic [LAST:0]            hsh;
  logic [LAST:0][KEY_W-1:0] word;
  logic [LAST:0][KEY_W-1:0] key;
  logic [LAST:0][PAY_W-1:0] pay;
  logic                     busy;
  logic                     eff_mode;
  logic                     adv_en;

  assign busy   = |vld[LAST:1];
  assign adv_en = out_ready_i;

  tps_mode_ctl u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .mode_i (hash_mode_i),
    .mode_o (eff_mode)
  );

  assign vld[0]  = in_valid_i;
  assign hsh[0]  = eff_mode;
  assign word[0] = in_key_i;
  assign key[0]  = in_key_i;
  assign pay[0]  = in_payload_i;

  for (genvar s = 0; s < LAST; s++) begin : g_stage
    tps_mix_stage #(.STEP(s)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (adv_en),
      .vld_i  (vld[s]),
      .hash_i (hsh[s]),
      .word_i (word[s]),
      .key_i  (key[s]),
      .pay_i  (pay[s]),
      .vld_o  (vld[s+1]),
      .hash_o (hsh[s+1]),
      .word_o (word[s+1]),
      .key_o  (key[s+1]),
      .pay_o  (pay[s+1])
    );
  end

  assign in_ready_o    = out_ready_i;
  assign out_valid_o   = vld[LAST];
  assign out_key_o     = key[LAST];
  assign out_payload_o = pay[LAST];
  assign out_index_o   = word[LAST][IDX_W-1:0];

  // R1
  hash_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && hsh[LAST]) |-> out_index_o == mix_full(out_key_o)[IDX_W-1:0]);

  // R2
  radix_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !hsh[LAST]) |-> out_index_o == out_key_o[IDX_W-1:0]);

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_key_o)
      && $stable(out_payload_o) && $stable(out_index_o));

  // R7
  for (genvar k = 2; k <= LAST; k++) begin : g_mode_chk
    same_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld[1] && vld[k]) |-> hsh[1] == hsh[k]);
  end
endmodule

// File: tb/tuple_part_sel_bench.sv
module tuple_part_sel_bench;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [31:0]      in_key;
  logic [31:0]      in_pay;
  logic             hmode;
  logic             oready;
  logic             in_ready;
  logic             out_valid;
  logic [31:0]      out_key;
  logic [31:0]      out_pay;
  logic [IDX_W-1:0] out_idx;

  int total = 0;
  int bad   = 0;

  // expected results, in acceptance order
  logic [31:0]      q_key [256];
  logic [31:0]      q_pay [256];
  logic [IDX_W-1:0] q_idx [256];
  int               wr = 0;
  int               rd = 0;
  logic             bmode = 1'b0;

  logic             held = 1'b0;
  logic [31:0]      held_key;
  logic [IDX_W-1:0] held_idx;

  always #2 clk = ~clk;

  tuple_part_sel #(.IDX_W(IDX_W)) u_tuple_part_sel (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_key_i(in_key),
    .in_payload_i(in_pay), .hash_mode_i(hmode), .out_ready_i(oready),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_key_o(out_key),
    .out_payload_o(out_pay), .out_index_o(out_idx)
  );

  function automatic logic [31:0] ref_mix(input logic [31:0] k);
    logic [31:0] h;
    h = k;
    h = h ^ (h >> 16);
    h = h * 32'h85ebca6b;
    h = h ^ (h >> 13);
    h = h * 32'hc2b2ae35;
    h = h ^ (h >> 16);
    return h;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check outputs, update model, drive inputs, advance to next falling edge
  task automatic cyc(input logic v, input logic [31:0] k, input logic [31:0] p,
                     input logic m, input logic r);
    if (held) begin
      check("R6 valid held", {63'd0, out_valid}, 64'd1);
      check("R6 key held", {32'd0, out_key}, {32'd0, held_key});
      check("R6 index held", {56'd0, out_idx}, {56'd0, held_idx});
    end
    if (out_valid) begin
      if (rd == wr) check("R4 output without input", 64'd1, 64'd0);
      else begin
        check("R3 tuple", {out_key, out_pay}, {q_key[rd % 256], q_pay[rd % 256]});
        check("R1/R2 index", {56'd0, out_idx}, {56'd0, q_idx[rd % 256]});
      end
    end
    if (wr == rd) bmode = m;
    held     = out_valid && !r;
    held_key = out_key;
    held_idx = out_idx;
    if (out_valid && r && rd != wr) rd++;
    if (v && r) begin
      q_key[wr % 256] = k;
      q_pay[wr % 256] = p;
      q_idx[wr % 256] = bmode ? ref_mix(k)[IDX_W-1:0] : k[IDX_W-1:0];
      wr++;
    end
    in_valid = v; in_key = k; in_pay = p; hmode = m; oready = r;
    #1;
    check("R6 in_ready follows out_ready", {63'd0, in_ready}, {63'd0, r});
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) cyc(1'b0, '0, '0, hmode, 1'b1);
    check("R4 all delivered", 64'(wr - rd), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_pay = '0; hmode = 1'b0; oready = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 valid low in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid low after reset", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_latency();
    cyc(1'b1, 32'h1234_5678, 32'hcafe_0001, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, '0, 1'b1, 1'b1);
    check("R4 not yet after 4 edges", {63'd0, out_valid}, 64'd0);
    cyc(1'b0, '0, '0, 1'b1, 1'b1);
    check("R4 valid after 5 edges", {63'd0, out_valid}, 64'd1);
    check("R1 known key", {56'd0, out_idx}, {56'd0, ref_mix(32'h1234_5678)[IDX_W-1:0]});
    drain();
  endtask

  task automatic t_hash_burst();
    int seen = 0;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] k = (i == 0) ? 32'h0 : (i == 1) ? 32'hffff_ffff : 32'h9e37_79b9 * i;
      if (out_valid) seen++;
      cyc(1'b1, k, 32'h100 + i, 1'b1, 1'b1);
    end
    check("R5 continuous output in burst", 64'(seen), 64'd7);
    drain();
  endtask

  task automatic t_radix_burst();
    for (int i = 0; i < 10; i++) cyc(1'b1, 32'h0101_0000 + 32'(i * 37), 32'hab00 + i, 1'b0, 1'b1);
    drain();
  endtask

  task automatic t_stall();
    for (int i = 0; i < 7; i++) cyc(1'b1, 32'h5000 + i * 3, 32'h77 + i, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b1, 32'hdead_0000 + i, 32'h0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 32'h6000 + i, 32'h88 + i, 1'b1, 1'b1);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    cyc(1'b0, '0, '0, 1'b1, 1'b0);
    drain();
  endtask

  task automatic t_mode_hold();
    // burst starts in hash mode; pin flips to radix mid-burst
    for (int i = 0; i < 4; i++) cyc(1'b1, 32'hc001_0000 + i, 32'h10 + i, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b1, 32'hc002_0000 + i, 32'h20 + i, 1'b0, 1'b1);
    cyc(1'b0, '0, '0, 1'b0, 1'b1);
    cyc(1'b1, 32'hc003_0000, 32'h30, 1'b0, 1'b1);
    drain();
    // empty now: radix applies at once
    cyc(1'b1, 32'h0000_00a5, 32'h40, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b0, '0, '0, 1'b0, 1'b1);
    check("R7 radix after drain", {56'd0, out_idx}, 64'ha5);
    drain();
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_hash_burst();
    t_radix_burst();
    t_stall();
    t_mode_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule